// File: doc/BRIEF.md
# GPIO Bank Controller

A bank of 32 general-purpose pins behind a small memory-mapped register port. Software writes a full word or uses separate set and clear aliases to change individual data and direction bits without a read-modify-write sequence. Each pin can be an output driving its data bit or an input. For an input pin, the data bit also picks a pull-up or a pull-down, unless that pin's pull is disabled. A per-pin select output tells neighbouring logic to take over the pad for an alternate function.

Pin inputs pass through a two-stage synchronizer. Rising and falling edges of the synchronized levels can each raise a sticky status bit, and the two edge masks are independent per pin. Status bits are cleared by writing ones to a clear alias. One combined interrupt line goes high while any status bit is set. Four of these banks at a 4 KiB stride make a 128-pin controller. That decoding lives outside this block.

The register port is plain and has no back-pressure. A write takes effect on the clock edge where `wr_en` is high. A read is combinational from `addr` and has no wait states, so no valid/ready handshake is needed.

Top module: `gpio_bank`

## Requirements
- R1: Writing 1 to a bit at offset 0x04 sets that data bit, and writing 1 at 0x08 clears it. Offsets 0x14 and 0x18 do the same on the direction register. Bits written as 0 stay unchanged. These four aliases, and the clear alias at 0x4C, read back as zero.
- R2: Full-word read/write registers sit at these offsets: 0x00 data, 0x0C pull-disable, 0x10 direction, 0x20 alternate-function select, 0x40 rising mask, 0x44 falling mask. Offset 0x48 reads the status and ignores writes. Any other word offset, or any address at or above 0x100, reads zero and ignores writes. The two low address bits are ignored.
- R3: `pin_oe` equals the direction register, where 1 means output. `pin_out` equals the data register.
- R4: For a pin with direction 0 and pull-disable 0, `pull_up` equals its data bit and `pull_down` equals its inverse. Otherwise both are 0.
- R5: A read of offset 0x00 returns, for output pins, the data bit. For input pins it returns the pin level sampled two clock edges earlier, through a two-flop synchronizer.
- R6: `alt_sel` equals the alternate-function select register.
- R7: A 0-to-1 change of a synchronized pin sets its status bit if its rising-mask bit is 1. A 1-to-0 change sets it if its falling-mask bit is 1. The status bit is set on the third clock edge after the pin changes, and a pin may have both masks set.
- R8: Writing 1 to a bit at 0x4C clears that status bit, and other bits are kept. If an enabled edge and a clear hit the same bit on the same edge, the bit stays set.
- R9: `irq` is 1 exactly when at least one status bit is set.
- R10: Reset (`rst_n` low) clears data, direction, pull-disable, alternate select, both masks, status and the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte address within the bank window |
| wr_en | input | 1 | Write strobe, acts on the rising clock edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| pin_in | input | 32 | Pad input levels (asynchronous) |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Pad output enables |
| pull_up | output | 32 | Per-pin pull-up enable |
| pull_down | output | 32 | Per-pin pull-down enable |
| alt_sel | output | 32 | Per-pin alternate-function takeover |
| irq | output | 1 | Combined interrupt |

## Verification
The set and clear aliases are driven with masks that overlap bits already at 1 and bits already at 0. This separates a true set/clear from a plain overwrite and from swapped aliases. Pin inputs move whole half-words in opposite directions while the rising and falling masks cover different halves, and one pin has both masks set. This shows whether each mask gates only its own edge direction. A clear is timed onto the same edge where a new rising edge arrives, which separates edge-wins from clear-wins. Writes to the status offset and to a hole in the map show that they change nothing.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned OFS_W = 8;

  localparam logic [OFS_W-1:0] OFS_DATA    = 8'h00;
  localparam logic [OFS_W-1:0] OFS_DSET    = 8'h04;
  localparam logic [OFS_W-1:0] OFS_DCLR    = 8'h08;
  localparam logic [OFS_W-1:0] OFS_PDIS    = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_DIR     = 8'h10;
  localparam logic [OFS_W-1:0] OFS_DIRSET  = 8'h14;
  localparam logic [OFS_W-1:0] OFS_DIRCLR  = 8'h18;
  localparam logic [OFS_W-1:0] OFS_ALT     = 8'h20;
  localparam logic [OFS_W-1:0] OFS_RMSK    = 8'h40;
  localparam logic [OFS_W-1:0] OFS_FMSK    = 8'h44;
  localparam logic [OFS_W-1:0] OFS_STAT    = 8'h48;
  localparam logic [OFS_W-1:0] OFS_ICLR    = 8'h4C;

  typedef struct packed {
    logic data_wr;
    logic data_set;
    logic data_clr;
    logic pdis_wr;
    logic dir_wr;
    logic dir_set;
    logic dir_clr;
    logic alt_wr;
    logic rmsk_wr;
    logic fmsk_wr;
    logic int_clr;
  } wr_strobe_t;

  function automatic wr_strobe_t decode_write(input logic en, input logic [OFS_W-1:0] ofs);
    wr_strobe_t s;
    s = '0;
    if (en) begin
      unique case (ofs)
        OFS_DATA:   s.data_wr  = 1'b1;
        OFS_DSET:   s.data_set = 1'b1;
        OFS_DCLR:   s.data_clr = 1'b1;
        OFS_PDIS:   s.pdis_wr  = 1'b1;
        OFS_DIR:    s.dir_wr   = 1'b1;
        OFS_DIRSET: s.dir_set  = 1'b1;
        OFS_DIRCLR: s.dir_clr  = 1'b1;
        OFS_ALT:    s.alt_wr   = 1'b1;
        OFS_RMSK:   s.rmsk_wr  = 1'b1;
        OFS_FMSK:   s.fmsk_wr  = 1'b1;
        OFS_ICLR:   s.int_clr  = 1'b1;
        default:    s = '0;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int unsigned N      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  localparam int unsigned DEPTH = STAGES + 1;

  logic [N-1:0] chain [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
  assign fall  = ~chain[STAGES-1] & chain[STAGES];

endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wr_strobe_t   stb,
  input  logic [N-1:0] wd,
  output logic [N-1:0] data_q,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] pdis_q,
  output logic [N-1:0] alt_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      pdis_q <= '0;
      alt_q  <= '0;
    end else begin
      if (stb.data_wr)       data_q <= wd;
      else if (stb.data_set) data_q <= data_q | wd;
      else if (stb.data_clr) data_q <= data_q & ~wd;

      if (stb.dir_wr)        dir_q <= wd;
      else if (stb.dir_set)  dir_q <= dir_q | wd;
      else if (stb.dir_clr)  dir_q <= dir_q & ~wd;

      if (stb.pdis_wr)       pdis_q <= wd;
      if (stb.alt_wr)        alt_q  <= wd;
    end
  end

endmodule

// File: rtl/gpio_irq_ctl.sv
module gpio_irq_ctl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wr_strobe_t   stb,
  input  logic [N-1:0] wd,
  input  logic [N-1:0] rise,
  input  logic [N-1:0] fall,
  output logic [N-1:0] rmsk_q,
  output logic [N-1:0] fmsk_q,
  output logic [N-1:0] stat_q,
  output logic         irq
);

  logic [N-1:0] clr_mask;
  logic [N-1:0] hits;
  logic [N-1:0] stat_d;

  always_comb begin
    clr_mask = stb.int_clr ? wd : '0;
    hits     = (rise & rmsk_q) | (fall & fmsk_q);
    stat_d   = (stat_q & ~clr_mask) | hits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rmsk_q <= '0;
      fmsk_q <= '0;
      stat_q <= '0;
    end else begin
      if (stb.rmsk_wr) rmsk_q <= wd;
      if (stb.fmsk_wr) fmsk_q <= wd;
      stat_q <= stat_d;
    end
  end

  assign irq = |stat_q;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [N-1:0]      wr_data,
  output logic [N-1:0]      rd_data,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic [N-1:0]      pull_up,
  output logic [N-1:0]      pull_down,
  output logic [N-1:0]      alt_sel,
  output logic              irq
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [ADDR_W-1:0] addr_hi;
  logic              in_win;
  logic [OFS_W-1:0]  ofs;
  wr_strobe_t        stb;

  logic [N-1:0] data_q, dir_q, pdis_q, alt_q;
  logic [N-1:0] rmsk_q, fmsk_q, stat_q;
  logic [N-1:0] lvl, rise, fall;
  logic [N-1:0] pull_on;

  assign addr_hi = addr >> OFS_W;
  assign in_win  = (addr_hi == '0);
  assign ofs     = {addr[OFS_W-1:2], 2'b00};
  assign stb     = decode_write(wr_en && in_win, ofs);

  gpio_sync_edge #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .level    (lvl),
    .rise     (rise),
    .fall     (fall)
  );

  gpio_pin_cfg #(.N(N)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .wd     (wr_data),
    .data_q (data_q),
    .dir_q  (dir_q),
    .pdis_q (pdis_q),
    .alt_q  (alt_q)
  );

  gpio_irq_ctl #(.N(N)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .wd     (wr_data),
    .rise   (rise),
    .fall   (fall),
    .rmsk_q (rmsk_q),
    .fmsk_q (fmsk_q),
    .stat_q (stat_q),
    .irq    (irq)
  );

  always_comb begin
    rd_data = '0;
    if (in_win) begin
      case (ofs)
        OFS_DATA: rd_data = (dir_q & data_q) | (~dir_q & lvl);
        OFS_PDIS: rd_data = pdis_q;
        OFS_DIR:  rd_data = dir_q;
        OFS_ALT:  rd_data = alt_q;
        OFS_RMSK: rd_data = rmsk_q;
        OFS_FMSK: rd_data = fmsk_q;
        OFS_STAT: rd_data = stat_q;
        default:  rd_data = '0;
      endcase
    end
  end

  assign pull_on   = ~dir_q & ~pdis_q;
  assign pin_out   = data_q;
  assign pin_oe    = dir_q;
  assign pull_up   = pull_on & data_q;
  assign pull_down = pull_on & ~data_q;
  assign alt_sel   = alt_q;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [N-1:0]      wr_data,
  input logic [N-1:0]      rd_data,
  input logic [N-1:0]      pin_out,
  input logic [N-1:0]      pin_oe,
  input logic [N-1:0]      pull_up,
  input logic [N-1:0]      pull_down,
  input logic              irq,
  input logic [N-1:0]      rmask,
  input logic [N-1:0]      fmask
);

  localparam logic [ADDR_W-1:0] A_DCLR   = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_DSET   = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_DIRSET = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_DIRCLR = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_ICLR   = ADDR_W'(8'h4C);

  a_r1_dir_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIRSET) |=> ((pin_oe & $past(wr_data)) == $past(wr_data)));

  a_r1_data_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DCLR) |=> ((pin_out & $past(wr_data)) == '0));

  a_r1_alias_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_DSET || addr == A_DCLR || addr == A_DIRSET || addr == A_DIRCLR || addr == A_ICLR)
      |-> (rd_data == '0));

  a_r4_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ((pull_up & pull_down) == '0) && (((pull_up | pull_down) & pin_oe) == '0));

  a_r9_quiet_without_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (rmask == '0 && fmask == '0 && !irq) |=> !irq);

endmodule

bind gpio_bank gpio_bank_chk #(.N(N), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .pull_up   (pull_up),
  .pull_down (pull_down),
  .irq       (irq),
  .rmask     (rmsk_q),
  .fmask     (fmsk_q)
);

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;

  localparam int N = 32;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [N-1:0]  wr_data = '0;
  logic [N-1:0]  rd_data;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe, pull_up, pull_down, alt_sel;
  logic          irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_bank #(.N(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pull_up(pull_up), .pull_down(pull_down), .alt_sel(alt_sel), .irq(irq)
  );

  // Behavioural reference state
  logic [N-1:0] m_data, m_dir, m_pdis, m_alt, m_rm, m_fm, m_stat;
  logic [N-1:0] hist[$];

  function automatic logic [N-1:0] m_read(input logic [AW-1:0] a);
    logic [N-1:0] r;
    r = '0;
    if (a < 12'h100) begin
      case (a & 12'hFFC)
        12'h000: r = (m_dir & m_data) | (~m_dir & hist[1]);
        12'h00C: r = m_pdis;
        12'h010: r = m_dir;
        12'h020: r = m_alt;
        12'h040: r = m_rm;
        12'h044: r = m_fm;
        12'h048: r = m_stat;
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data = '0; m_dir = '0; m_pdis = '0; m_alt = '0;
      m_rm = '0; m_fm = '0; m_stat = '0;
      hist = {};
      repeat (4) hist.push_front('0);
    end else begin
      logic [N-1:0] rs, fl, clr;
      logic [AW-1:0] a;
      a  = addr & 12'hFFC;
      rs = hist[1] & ~hist[2];
      fl = ~hist[1] & hist[2];
      clr = (wr_en && a == 12'h04C) ? wr_data : '0;
      m_stat = (m_stat & ~clr) | (rs & m_rm) | (fl & m_fm);
      if (wr_en) begin
        case (a)
          12'h000: m_data = wr_data;
          12'h004: m_data = m_data | wr_data;
          12'h008: m_data = m_data & ~wr_data;
          12'h00C: m_pdis = wr_data;
          12'h010: m_dir  = wr_data;
          12'h014: m_dir  = m_dir | wr_data;
          12'h018: m_dir  = m_dir & ~wr_data;
          12'h020: m_alt  = wr_data;
          12'h040: m_rm   = wr_data;
          12'h044: m_fm   = wr_data;
          default: ;
        endcase
      end
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 rd_data vs model", rd_data, m_read(addr));
      chk("R3 pin_out", pin_out, m_data);
      chk("R3 pin_oe", pin_oe, m_dir);
      chk("R4 pull_up", pull_up, ~m_dir & ~m_pdis & m_data);
      chk("R4 pull_down", pull_down, ~m_dir & ~m_pdis & ~m_data);
      chk("R6 alt_sel", alt_sel, m_alt);
      chk("R9 irq", {31'd0, irq}, {31'd0, (m_stat != '0)});
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd_expect(input logic [AW-1:0] a, input logic [N-1:0] exp, input string tag);
    addr = a;
    @(negedge clk);
    chk(tag, rd_data, exp);
    @(posedge clk); #1;
  endtask

  task automatic summary;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      summary();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R10: reset state
    chk("R10 reset pin_oe", pin_oe, '0);
    chk("R10 reset alt_sel", alt_sel, '0);
    chk("R10 reset irq", {31'd0, irq}, '0);
    rd_expect(12'h010, 32'h0000_0000, "R10 reset direction");
    rd_expect(12'h044, 32'h0000_0000, "R10 reset fall mask");

    // R1: set/clear aliases
    wr(12'h000, 32'hA5A5_0F0F);
    wr(12'h014, 32'hFFFF_0000);
    wr(12'h004, 32'h0000_00F0);
    wr(12'h008, 32'h0F00_0000);
    wr(12'h018, 32'h00F0_0000);
    rd_expect(12'h010, 32'hFF0F_0000, "R1 direction after set/clear");
    chk("R1 data after set/clear", pin_out, 32'hA0A5_0FFF);
    rd_expect(12'h004, 32'h0, "R1 data-set alias reads zero");
    rd_expect(12'h018, 32'h0, "R1 dir-clear alias reads zero");
    rd_expect(12'h000, 32'hA005_0000, "R5 data read with inputs low");

    // R4: pulls
    wr(12'h00C, 32'h0000_FF00);
    chk("R4 pull_up pattern", pull_up, 32'h00A0_00FF);
    chk("R4 pull_down pattern", pull_down, 32'h0050_0000);

    // R6, R2: alternate select and ignored writes
    wr(12'h020, 32'h1234_5678);
    chk("R6 alt_sel value", alt_sel, 32'h1234_5678);
    wr(12'h01C, 32'hDEAD_BEEF);
    wr(12'h048, 32'hFFFF_FFFF);
    wr(12'h120, 32'hFFFF_FFFF);
    rd_expect(12'h048, 32'h0, "R2 status ignores writes");
    rd_expect(12'h01C, 32'h0, "R2 hole reads zero");
    rd_expect(12'h022, 32'h1234_5678, "R2 low address bits ignored / out-of-window write ignored");

    // R5: synchronized input level
    pin_in = 32'h0000_FFFF;
    step(1);
    rd_expect(12'h000, 32'hA005_0000, "R5 level not visible after one edge");
    rd_expect(12'h000, 32'hA005_FFFF, "R5 level visible through sync");
    chk("R9 no irq without masks", {31'd0, irq}, '0);

    // R7: independent edge masks
    wr(12'h040, 32'h0000_FFFF);
    wr(12'h044, 32'hFFFF_0001);
    pin_in = 32'hFFFF_0000;
    step(2);
    chk("R7 status not yet set after two edges", {31'd0, irq}, '0);
    step(1);
    rd_expect(12'h048, 32'h0000_0001, "R7 falling edge with both masks");
    chk("R9 irq high", {31'd0, irq}, 32'd1);
    pin_in = 32'h0000_FFFF;
    step(4);
    rd_expect(12'h048, 32'hFFFF_FFFF, "R7 rising low half and falling high half");

    // R8: clear
    wr(12'h04C, 32'h0000_FF00);
    rd_expect(12'h048, 32'hFFFF_00FF, "R8 partial clear keeps others");
    wr(12'h04C, 32'hFFFF_FFFF);
    rd_expect(12'h048, 32'h0, "R8 full clear");
    chk("R9 irq low after clear", {31'd0, irq}, '0);

    // R8: edge and clear on the same edge, edge wins
    pin_in = 32'h0000_FFFD;
    step(4);
    rd_expect(12'h048, 32'h0, "R8 setup: masked-off fall leaves status clear");
    pin_in = 32'h0000_FFFF;
    step(2);
    wr(12'h04C, 32'h0000_0002);
    rd_expect(12'h048, 32'h0000_0002, "R8 edge wins over same-cycle clear");

    step(3);
    summary();
  end

endmodule